// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a byte-addressed serial memory that sits on a two-wire bus as a slave. It oversamples the clock and data lines with the system clock, recognises the bus framing conditions, collects bits most significant first, and answers its device address with an acknowledge driven through an open-drain pull-down enable. The block-select bits carried in the address byte are handed to the memory controller as the upper bits of the memory address.

Toward the memory controller it presents each received byte with a one-cycle strobe. It also gives a strobe when a transaction is accepted (with the direction bit and block bits), a strobe when an addressed transaction is closed by STOP, and a strobe each time it takes a read byte from `rd_data`. The controller holds `rd_data` at the byte under its current pointer and advances the pointer on each take strobe. It raises `busy` while its internal programming cycle runs, and the front end then stays silent to its own address so the master can poll. The system clock must run at least eight times faster than the bus clock.

Top module: `twi_mem_front`

## Requirements
- R1: After reset `sda_pull`, `rx_valid`, `txn_start`, `stop_pulse` and `rd_take` are 0. A STOP (data rising while clock high) that ends an accepted transaction gives exactly one `stop_pulse`.
- R2: An address byte whose upper four bits are not 1010 gets no acknowledge. Later bytes up to the next START are not acknowledged and produce no `rx_valid`.
- R3: With MEM_AW=11, address bits 3:1 appear on `blk_sel` after acceptance and no pin is compared.
- R4: With MEM_AW=10, address bit 3 must equal `dev_pins[2]` for acceptance, and bits 2:1 appear on `blk_sel`.
- R5: On acceptance, `sda_pull` is 1 during the ninth clock, `txn_start` pulses once and `rw_bit` equals address bit 0 (1 = read).
- R6: While `busy` is 1 when the address byte completes, the address is not acknowledged and `txn_start` stays 0. Once `busy` is 0 the same address is accepted.
- R7: In a write transaction every received byte is assembled MSB first, shown on `rx_byte` with a one-cycle `rx_valid`, and acknowledged on the ninth clock.
- R8: In a read transaction each byte is taken from `rd_data` with one `rd_take` pulse and shifted out MSB first, with `sda_pull` = 1 for a 0 bit.
- R9: A master acknowledge (data low on the ninth clock) after a read byte starts the next byte. A missing acknowledge makes the block release SDA until the next START or STOP, with no further `rd_take`.
- R10: A START in the middle of a byte abandons that byte with no `rx_valid` and starts a fresh address reception.
- R11: `sda_pull` changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND result) |
| dev_pins | input | 3 | Strap pins; bit 2 compared when MEM_AW=10 |
| busy | input | 1 | Internal programming cycle in progress |
| rd_data | input | 8 | Byte at the controller's current read pointer |
| sda_pull | output | 1 | 1 = pull the data line low |
| rx_byte | output | 8 | Last received word-address or data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| txn_start | output | 1 | One-cycle strobe when an address is accepted |
| rw_bit | output | 1 | Direction of the accepted transaction, 1 = read |
| blk_sel | output | MEM_AW-8 | Block bits from the accepted address |
| stop_pulse | output | 1 | One-cycle strobe on STOP closing an accepted transaction |
| rd_take | output | 1 | One-cycle strobe when a read byte is loaded |

## Verification
The bench sweeps address bytes against two instances, one per memory size, so a decoder that compares the strap pin in the wrong size, or drops the prefix check, acknowledges the wrong bytes or reports wrong block bits. Busy polling is tested by a refused address followed by an accepted one; a design that samples `busy` late or ignores it acknowledges during programming. A read burst closed by a missing master acknowledge, with one extra byte clocked after it, catches a slave that keeps driving or keeps fetching. A START placed halfway through a data byte catches an engine that completes the stale byte or fails to re-enter address reception.

// File: rtl/twi_front_pkg.sv
package twi_front_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_WAIT_STOP
  } twi_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_in;
          sda_chain <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_in};
          sda_chain <= {sda_chain[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_addr_decode.sv
module twi_addr_decode #(
  parameter int         BLK_W  = 3,
  parameter logic [3:0] PREFIX = 4'b1010
) (
  input  logic [7:1]       abyte,
  input  logic [2:0]       pins,
  output logic             hit,
  output logic [BLK_W-1:0] blk
);
  logic pin_ok;

  generate
    if (BLK_W >= 3) begin : g_no_pin
      logic unused_pins;
      assign unused_pins = ^pins;
      assign pin_ok = 1'b1;
    end else begin : g_pin
      assign pin_ok = (abyte[3:BLK_W+1] == pins[2:BLK_W]);
    end
  endgenerate

  assign blk = abyte[BLK_W:1];
  assign hit = (abyte[7:4] == PREFIX) && pin_ok;
endmodule

// File: rtl/twi_mem_front.sv
module twi_mem_front
  import twi_front_pkg::*;
#(
  parameter int         MEM_AW      = 11,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010,
  localparam int        BLK_W       = MEM_AW - 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [2:0]       dev_pins,
  input  logic             busy,
  input  logic [7:0]       rd_data,
  output logic             sda_pull,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             txn_start,
  output logic             rw_bit,
  output logic [BLK_W-1:0] blk_sel,
  output logic             stop_pulse,
  output logic             rd_take
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit;
  logic [BLK_W-1:0] blk;
  twi_state_t state;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       m_ack;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_addr_decode #(.BLK_W(BLK_W), .PREFIX(DEV_PREFIX)) u_dec (
    .abyte(sh[7:1]), .pins(dev_pins), .hit(hit), .blk(blk)
  );

  always_ff @(posedge clk) begin
    rx_valid   <= 1'b0;
    txn_start  <= 1'b0;
    stop_pulse <= 1'b0;
    rd_take    <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      m_ack    <= 1'b0;
      sda_pull <= 1'b0;
      rx_byte  <= '0;
      rw_bit   <= 1'b0;
      blk_sel  <= '0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      if (state != ST_IDLE && state != ST_ADDR) stop_pulse <= 1'b1;
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == BITS_PER_BYTE) begin
            if (hit && !busy) begin
              sda_pull  <= 1'b1;
              txn_start <= 1'b1;
              rw_bit    <= sh[0];
              blk_sel   <= blk;
              state     <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw_bit) begin
              tx       <= rd_data;
              sda_pull <= ~rd_data[7];
              rd_take  <= 1'b1;
              state    <= ST_RD_BYTE;
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == BITS_PER_BYTE) begin
            rx_byte  <= sh;
            rx_valid <= 1'b1;
            sda_pull <= 1'b1;
            state    <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            state    <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == BITS_PER_BYTE) begin
            sda_pull <= 1'b0;
            m_ack    <= 1'b0;
            state    <= ST_RD_ACK;
          end else if (scl_fall && cnt != 4'd0) begin
            tx       <= {tx[6:0], 1'b0};
            sda_pull <= ~tx[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_s) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (m_ack) begin
              tx       <= rd_data;
              sda_pull <= ~rd_data[7];
              rd_take  <= 1'b1;
              state    <= ST_RD_BYTE;
            end else begin
              state <= ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_mem_front_chk.sv
module twi_mem_front_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_pull,
  input logic busy,
  input logic txn_start,
  input logic rx_valid,
  input logic stop_pulse
);
  a_r1_stop_single: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);

  a_r5_ack_with_start: assert property (@(posedge clk) disable iff (rst)
    txn_start |-> sda_pull);

  a_r6_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    txn_start |-> !$past(busy));

  a_r7_rx_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_s);

  a_r1_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({txn_start, rx_valid, stop_pulse}));
endmodule

bind twi_mem_front twi_mem_front_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull), .busy(busy),
  .txn_start(txn_start), .rx_valid(rx_valid), .stop_pulse(stop_pulse)
);

// File: tb/twi_mem_front_bench.sv
module twi_mem_front_bench;
  localparam int Q = 6;

  function automatic logic [7:0] rd_val(input int k);
    logic [7:0] kk;
    kk = k[7:0];
    return 8'hA5 ^ (kk * 8'd37);
  endfunction

  // {addr[15:8], busy[7], ackA[6], ackB[5], blkA[4:2], pad[1:0]}
  localparam logic [15:0] VEC [8] = '{
    {8'hA0, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0},
    {8'hAE, 1'b0, 1'b1, 1'b1, 3'd7, 2'd0},
    {8'hAA, 1'b0, 1'b1, 1'b1, 3'd5, 2'd0},
    {8'hA6, 1'b0, 1'b1, 1'b0, 3'd3, 2'd0},
    {8'hB0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0},
    {8'h2A, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0},
    {8'hAC, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0},
    {8'hA8, 1'b0, 1'b1, 1'b1, 3'd4, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  int   rd_ptr = 0;
  int   n_chk = 0, n_bad = 0;
  int   n_rx = 0, n_txn = 0, n_stop = 0, n_take = 0;
  logic [7:0] last_rx = 8'h00, prev_rx = 8'h00;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  wire [7:0] rd_data = rd_val(rd_ptr);
  logic pull_a, pull_b;
  wire  sda_a = m_sda & ~pull_a;
  wire  sda_b = m_sda & ~pull_b;

  logic [7:0] rx_byte_a, rx_byte_b;
  logic rx_valid_a, txn_a, rw_a, stop_a, take_a;
  logic rx_valid_b, txn_b, rw_b, stop_b, take_b;
  logic [2:0] blk_a;
  logic [1:0] blk_b;

  twi_mem_front u_twi_mem_front (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_a), .dev_pins(3'b000),
    .busy(busy), .rd_data(rd_data), .sda_pull(pull_a), .rx_byte(rx_byte_a),
    .rx_valid(rx_valid_a), .txn_start(txn_a), .rw_bit(rw_a), .blk_sel(blk_a),
    .stop_pulse(stop_a), .rd_take(take_a)
  );

  twi_mem_front #(.MEM_AW(10)) u_twi_mem_front_small (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_b), .dev_pins(3'b100),
    .busy(busy), .rd_data(rd_data), .sda_pull(pull_b), .rx_byte(rx_byte_b),
    .rx_valid(rx_valid_b), .txn_start(txn_b), .rw_bit(rw_b), .blk_sel(blk_b),
    .stop_pulse(stop_b), .rd_take(take_b)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid_a) begin
        prev_rx <= last_rx;
        last_rx <= rx_byte_a;
        n_rx    <= n_rx + 1;
      end
      if (txn_a)  n_txn  <= n_txn + 1;
      if (stop_a) n_stop <= n_stop + 1;
      if (take_a) begin
        n_take <= n_take + 1;
        rd_ptr <= rd_ptr + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_a, output logic ack_b);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; q(); m_scl = 1'b1; q();
    ack_a = pull_a; ack_b = pull_b;
    q(); m_scl = 1'b0; q();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; q(); m_scl = 1'b1; q(); b[i] = sda_a; q(); m_scl = 1'b0; q();
    end
    put_bit(!give_ack);
    m_sda = 1'b1;
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    logic aa, ab;
    logic [7:0] rb;
    int t0, r0, s0, k0, base;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    q();
    chk("R1 reset sda_pull", pull_a, 0);
    chk("R1 reset strobes", {rx_valid_a, txn_a, stop_a, take_a}, 0);

    // address sweep over both sizes
    for (int i = 0; i < 8; i++) begin
      busy = VEC[i][7];
      t0 = n_txn;
      bus_start();
      send_byte(VEC[i][15:8], aa, ab);
      chk($sformatf("R2 R5 R6 ack large addr=%0h", VEC[i][15:8]), aa, VEC[i][6]);
      chk($sformatf("R4 ack small addr=%0h", VEC[i][15:8]), ab, VEC[i][5]);
      if (VEC[i][6]) begin
        chk("R3 blk_sel large", blk_a, VEC[i][4:2]);
        chk("R5 rw_bit write", rw_a, 0);
      end
      if (VEC[i][5]) chk("R4 blk_sel small", blk_b, VEC[i][3:2]);
      chk("R5 R6 txn_start count", n_txn - t0, VEC[i][6] ? 1 : 0);
      bus_stop();
      busy = 1'b0;
    end

    // R7 write burst and R1 stop strobe
    r0 = n_rx; s0 = n_stop;
    bus_start();
    send_byte(8'hA4, aa, ab);
    chk("R3 blk_sel 2", blk_a, 2);
    send_byte(8'h5C, aa, ab);
    chk("R7 ack byte 1", aa, 1);
    send_byte(8'h81, aa, ab);
    chk("R7 ack byte 2", aa, 1);
    chk("R7 rx count", n_rx - r0, 2);
    chk("R7 first byte", prev_rx, 8'h5C);
    chk("R7 second byte", last_rx, 8'h81);
    bus_stop();
    chk("R1 stop pulse", n_stop - s0, 1);

    // R2 bytes after a foreign address are ignored
    r0 = n_rx; s0 = n_stop;
    bus_start();
    send_byte(8'h52, aa, ab);
    chk("R2 foreign address", aa, 0);
    send_byte(8'h33, aa, ab);
    chk("R2 data after foreign", aa, 0);
    chk("R2 no rx_valid", n_rx - r0, 0);
    bus_stop();
    chk("R2 no stop pulse", n_stop - s0, 0);

    // R6 busy polling
    busy = 1'b1; t0 = n_txn;
    bus_start();
    send_byte(8'hA0, aa, ab);
    chk("R6 busy refuses", aa, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(8'hA0, aa, ab);
    chk("R6 accepted after busy", aa, 1);
    bus_stop();
    chk("R6 txn count", n_txn - t0, 1);

    // R8 R9 read burst with final NACK
    base = rd_ptr; k0 = n_take; s0 = n_stop;
    bus_start();
    send_byte(8'hA1, aa, ab);
    chk("R5 read ack", aa, 1);
    chk("R5 rw_bit read", rw_a, 1);
    get_byte(1'b1, rb);
    chk("R8 R11 read byte 0", rb, rd_val(base));
    get_byte(1'b1, rb);
    chk("R9 read byte 1", rb, rd_val(base + 1));
    get_byte(1'b0, rb);
    chk("R9 read byte 2", rb, rd_val(base + 2));
    get_byte(1'b0, rb);
    chk("R9 released after nack", rb, 8'hFF);
    chk("R8 R9 rd_take count", n_take - k0, 3);
    bus_stop();
    chk("R1 stop after read", n_stop - s0, 1);

    // R10 repeated START mid-byte
    r0 = n_rx; t0 = n_txn;
    bus_start();
    send_byte(8'hA2, aa, ab);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    base = rd_ptr;
    bus_start();
    send_byte(8'hA3, aa, ab);
    chk("R10 ack after restart", aa, 1);
    chk("R10 blk_sel", blk_a, 1);
    chk("R10 rw_bit", rw_a, 1);
    chk("R10 no partial byte", n_rx - r0, 0);
    chk("R10 txn count", n_txn - t0, 2);
    get_byte(1'b0, rb);
    chk("R10 R8 read after restart", rb, rd_val(base));
    bus_stop();

    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end
endmodule